// File: doc/BRIEF.md
# Prescaled compare-match tick timer

A 24-bit up counter advanced by an input tick event through an 8-bit prescaler, matched against a 24-bit compare value. Software drives it through single-cycle write and read strobes with a word address. On a match the block sets a time-out flag, which can drive an interrupt line, a sticky wake request and one-cycle trigger pulses for a DMA engine and for neighbouring peripherals. Three counting behaviours are available: single-shot, repeating and free-running. A debug-halt input can freeze the count.

Compare writes act in different ways depending on the counting behaviour. In repeating mode with the smart-update option set, the new value is compared with the live count. The timer then keeps counting, times out at once, or restarts. Starting and stopping pass through a two-stage enable pipeline, and a read-only bit shows when the pipeline has caught up.

Top module: `cmp_tick_timer`

Register map (word address on `addr`):
- 0 control: [7:0] prescale P, [9:8] mode, [10] run, [11] interrupt enable, [12] wake enable, [13] smart-update select, [14] ignore debug halt, [15] active (read-only).
- 1 compare: [23:0] compare value C.
- 2 status: [0] time-out flag, [1] wake flag.
- 3 count: [23:0] count, [31] clear-busy (read-only).
- 4 trigger: [0] DMA trigger enable, [1] peripheral trigger enable.

Reads are registered: `rdata` shows, one edge after `rd_en`, the state sampled at that edge.

## Requirements
- R1: After reset, every register and output reads 0, except compare, which reads 0xFFFFFF.
- R2: When the enable pipeline is active, the count advances once per P+1 cycles that have `tick_in` high. A P of 0 means the count advances on every tick.
- R3: Mode 01 repeats. When the count would reach C, the time-out fires and the count returns to 0, so time-outs come every (P+1)*C ticks. In mode 11 the count passes through C and wraps from 0xFFFFFF to 0.
- R4: Modes 00 and 10 are single-shot. At the time-out the count returns to 0, the run bit and the active bit clear at the same edge, and counting stops.
- R5: The time-out flag (status bit 0) is set on a time-out. Writing 1 to the bit clears it. Writing 0 leaves it unchanged.
- R6: In mode 11, a compare write leaves the count untouched. In modes 00 and 10, and in mode 01 with the select bit clear, a compare write resets the count and the prescaler to 0.
- R7: In mode 01 with the select bit set, a new compare value above the count is taken while counting continues. A value equal to the count fires the time-out and restarts the count at 0. A value below the count resets the count to 0 without a time-out.
- R8: Run changes reach the counter through two register stages, and the active bit shows the result. Clearing run holds the count, and setting run again continues from the held value.
- R9: Any write to the count address sets the busy bit. At the next edge the count and the prescaler are cleared and the busy bit drops.
- R10: A control write whose prescale field differs from the current P clears the count and the prescaler. A control write with the same P leaves the count unchanged.
- R11: `irq` follows the flag ANDed with interrupt enable, one cycle later. While `irq` and wake enable are both high, the wake flag (status bit 1, driven on `wake`) is set. Writing 1 to the bit clears it.
- R12: While `dbg_halt` is high and the ignore bit is 0, the count holds. With the ignore bit set to 1, the count advances regardless of `dbg_halt`.
- R13: Each time-out produces a one-cycle pulse on `dma_trig` if trigger bit 0 is set, and on `per_trig` if trigger bit 1 is set. The pulse coincides with the edge that sets the flag.
- R14: `cfg_err` goes high one cycle after the compare value becomes 0 or 1, and drops once it is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Counting event, sampled every cycle |
| dbg_halt | input | 1 | Debugger halt request |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Sticky wake request |
| dma_trig | output | 1 | Time-out pulse toward DMA |
| per_trig | output | 1 | Time-out pulse toward peripherals |
| cfg_err | output | 1 | Compare value is 0 or 1 |

## Verification
The hold properties assume that the count changes only through the prescaler path, a compare or control write, or the busy clear. For that reason they exclude any cycle that has `wr_en` high. The bench uses a single strobe per cycle and keeps all writes and reads apart. The compare value stays at 2 or more whenever counting with triggers enabled, so time-outs are always separated. `tick_in` and `dbg_halt` change only at falling edges, and exact counts are produced by holding `tick_in` high for a known number of edges.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    MD_ONESHOT  = 2'b00,
    MD_PERIODIC = 2'b01,
    MD_ONESHOT2 = 2'b10,
    MD_CONT     = 2'b11
  } tt_mode_e;

  // word addresses
  localparam int A_CTRL = 0;
  localparam int A_CMP  = 1;
  localparam int A_STAT = 2;
  localparam int A_CNT  = 3;
  localparam int A_TRIG = 4;

  // control word bit positions (prescale occupies the low byte)
  localparam int B_MODE   = 8;
  localparam int B_RUN    = 10;
  localparam int B_IRQEN  = 11;
  localparam int B_WAKEEN = 12;
  localparam int B_PSEL   = 13;
  localparam int B_DBGIGN = 14;
  localparam int B_ACT    = 15;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [PSC_W-1:0] div,
  output logic             adv
);

  logic [PSC_W-1:0] pcnt_q;
  logic             last;

  assign last = (pcnt_q == div);
  assign adv  = step && last && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt_q <= '0;
    end else if (step) begin
      pcnt_q <= last ? '0 : pcnt_q + PSC_W'(1);
    end
  end

endmodule

// File: rtl/tt_enable_sync.sv
module tt_enable_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic kill,
  output logic active
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], req};
    end
  end

  assign active = sh_q[STAGES-1];

endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
  import tt_pkg::*;
#(
  parameter int               CNT_W   = 24,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             clr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_new,
  input  tt_mode_e         mode,
  input  logic             per_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             restart
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d, inc;

  always_comb begin
    inc     = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    hit     = 1'b0;
    restart = 1'b0;
    if (cmp_wr) cmp_d = cmp_new;
    if (clr) begin
      cnt_d = '0;
    end else if (cmp_wr) begin
      if (mode == MD_CONT) begin
        if (adv) begin
          cnt_d = inc;
          hit   = (inc == cmp_new);
        end
      end else if (mode == MD_PERIODIC && per_sel) begin
        if (cmp_new > cnt_q) begin
          if (adv) begin
            if (inc == cmp_new) begin
              hit   = 1'b1;
              cnt_d = '0;
            end else begin
              cnt_d = inc;
            end
          end
        end else if (cmp_new == cnt_q) begin
          hit     = 1'b1;
          cnt_d   = '0;
          restart = 1'b1;
        end else begin
          cnt_d   = '0;
          restart = 1'b1;
        end
      end else begin
        cnt_d   = '0;
        restart = 1'b1;
      end
    end else if (adv) begin
      if (inc == cmp_q) begin
        hit   = 1'b1;
        cnt_d = (mode == MD_CONT) ? inc : '0;
      end else begin
        cnt_d = inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= CMP_RST;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  assign cnt = cnt_q;
  assign cmp = cmp_q;

endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
  import tt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 24,
  parameter int PSC_W   = 8,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              dbg_halt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wake,
  output logic              dma_trig,
  output logic              per_trig,
  output logic              cfg_err
);

  localparam logic [CNT_W-1:0] CMP_RST = '1;

  logic             wr_ctrl, wr_cmp, wr_stat, wr_cnt, wr_trig;
  logic [PSC_W-1:0] psc_q;
  logic [1:0]       mode_q;
  logic             run_q, irq_en_q, wake_en_q, psel_q, dbg_ign_q;
  logic             dma_en_q, per_en_q;
  logic             to_flag_q, wk_flag_q, busy_q, irq_q, dma_q, per_q, err_q;
  logic             psc_chg, active, go, adv, os_stop;
  logic             core_hit, core_restart;
  logic [CNT_W-1:0] cnt, cmp;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

  assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_cmp  = wr_en && (addr == ADDR_W'(A_CMP));
  assign wr_stat = wr_en && (addr == ADDR_W'(A_STAT));
  assign wr_cnt  = wr_en && (addr == ADDR_W'(A_CNT));
  assign wr_trig = wr_en && (addr == ADDR_W'(A_TRIG));

  assign psc_chg = wr_ctrl && (wdata[PSC_W-1:0] != psc_q);
  assign go      = active && tick_in && !(dbg_halt && !dbg_ign_q) && !busy_q;
  assign os_stop = core_hit && !mode_q[0];

  tt_enable_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .req    (run_q),
    .kill   (os_stop),
    .active (active)
  );

  tt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .clr  (psc_chg || busy_q || core_restart),
    .step (go),
    .div  (psc_q),
    .adv  (adv)
  );

  tt_count_core #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) u_core (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .clr     (psc_chg || busy_q),
    .cmp_wr  (wr_cmp),
    .cmp_new (wdata[CNT_W-1:0]),
    .mode    (tt_mode_e'(mode_q)),
    .per_sel (psel_q),
    .cnt     (cnt),
    .cmp     (cmp),
    .hit     (core_hit),
    .restart (core_restart)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q     <= '0;
      mode_q    <= '0;
      run_q     <= 1'b0;
      irq_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
      psel_q    <= 1'b0;
      dbg_ign_q <= 1'b0;
      dma_en_q  <= 1'b0;
      per_en_q  <= 1'b0;
      to_flag_q <= 1'b0;
      wk_flag_q <= 1'b0;
      busy_q    <= 1'b0;
      irq_q     <= 1'b0;
      dma_q     <= 1'b0;
      per_q     <= 1'b0;
      err_q     <= 1'b0;
      rdata     <= '0;
    end else begin
      if (wr_ctrl) begin
        psc_q     <= wdata[PSC_W-1:0];
        mode_q    <= wdata[B_MODE+1:B_MODE];
        run_q     <= wdata[B_RUN];
        irq_en_q  <= wdata[B_IRQEN];
        wake_en_q <= wdata[B_WAKEEN];
        psel_q    <= wdata[B_PSEL];
        dbg_ign_q <= wdata[B_DBGIGN];
      end
      if (os_stop) run_q <= 1'b0;
      if (wr_trig) begin
        dma_en_q <= wdata[0];
        per_en_q <= wdata[1];
      end
      if (core_hit)                 to_flag_q <= 1'b1;
      else if (wr_stat && wdata[0]) to_flag_q <= 1'b0;
      if (irq_q && wake_en_q)       wk_flag_q <= 1'b1;
      else if (wr_stat && wdata[1]) wk_flag_q <= 1'b0;
      busy_q <= wr_cnt;
      irq_q  <= to_flag_q && irq_en_q;
      dma_q  <= core_hit && dma_en_q;
      per_q  <= core_hit && per_en_q;
      err_q  <= (cmp < CNT_W'(2));
      if (rd_en) rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_CTRL)) begin
      rd_mux[PSC_W-1:0]         = psc_q;
      rd_mux[B_MODE+1:B_MODE]   = mode_q;
      rd_mux[B_RUN]             = run_q;
      rd_mux[B_IRQEN]           = irq_en_q;
      rd_mux[B_WAKEEN]          = wake_en_q;
      rd_mux[B_PSEL]            = psel_q;
      rd_mux[B_DBGIGN]          = dbg_ign_q;
      rd_mux[B_ACT]             = active;
    end else if (addr == ADDR_W'(A_CMP)) begin
      rd_mux[CNT_W-1:0] = cmp;
    end else if (addr == ADDR_W'(A_STAT)) begin
      rd_mux[0] = to_flag_q;
      rd_mux[1] = wk_flag_q;
    end else if (addr == ADDR_W'(A_CNT)) begin
      rd_mux[CNT_W-1:0]  = cnt;
      rd_mux[DATA_W-1]   = busy_q;
    end else if (addr == ADDR_W'(A_TRIG)) begin
      rd_mux[0] = dma_en_q;
      rd_mux[1] = per_en_q;
    end
  end

  assign irq      = irq_q;
  assign wake     = wk_flag_q;
  assign dma_trig = dma_q;
  assign per_trig = per_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic             hit,
  input logic             oneshot,
  input logic             run,
  input logic             active,
  input logic             irq,
  input logic             to_flag,
  input logic             dma_trig,
  input logic             per_trig,
  input logic             dbg_halt,
  input logic             dbg_ign,
  input logic             wake_en,
  input logic             wk_flag
);

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_en && !busy) |=> $stable(cnt)); // R8

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dbg_halt && !dbg_ign && !wr_en && !busy) |=> $stable(cnt)); // R12

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cnt == '0)); // R9

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (hit && oneshot) |=> (!run && !active)); // R4

  AST_TRIG_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (dma_trig || per_trig) |-> to_flag); // R13

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(to_flag)); // R11

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (rst)
    (irq && wake_en) |=> wk_flag); // R11

endmodule

bind cmp_tick_timer tt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .busy     (busy_q),
  .cnt      (cnt),
  .hit      (core_hit),
  .oneshot  (!mode_q[0]),
  .run      (run_q),
  .active   (active),
  .irq      (irq),
  .to_flag  (to_flag_q),
  .dma_trig (dma_trig),
  .per_trig (per_trig),
  .dbg_halt (dbg_halt),
  .dbg_ign  (dbg_ign_q),
  .wake_en  (wake_en_q),
  .wk_flag  (wk_flag_q)
);

// File: tb/cmp_tick_timer_tb_top.sv
module cmp_tick_timer_tb_top;

  localparam logic [2:0] AC = 3'd0, AM = 3'd1, AS = 3'd2, AN = 3'd3, AT = 3'd4;
  // periodic interval table: prescale, compare, tick spacing
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{'{0, 3, 1}, '{0, 7, 1}, '{2, 4, 1},
                                 '{1, 5, 2}, '{3, 2, 1}, '{7, 3, 2}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_halt = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake, dma_trig, per_trig, cfg_err, tick_in;

  logic tick_force = 1'b0, tick_auto = 1'b0, tick_ph = 1'b0;
  int   tick_div = 1;
  assign tick_in = tick_auto ? ((tick_div == 1) || tick_ph) : tick_force;

  always #5 clk = ~clk;
  always @(negedge clk) tick_ph <= ~tick_ph;

  cmp_tick_timer dut_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wake(wake), .dma_trig(dma_trig), .per_trig(per_trig),
    .cfg_err(cfg_err)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] c_psc = '0;
  logic [1:0] c_mode = '0;
  logic c_run = 0, c_ie = 0, c_we = 0, c_ps = 0, c_dbg = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic put_ctrl();
    wr(AC, {17'b0, c_dbg, c_ps, c_we, c_ie, c_run, c_mode, c_psc});
  endtask

  task automatic tick_n(input int n);
    tick_force = 1'b1;
    repeat (n) @(negedge clk);
    tick_force = 1'b0;
  endtask

  task automatic measure(input bit use_per, output int iv, output int other);
    int guard;
    guard = 0; iv = 0; other = 0;
    while (!(use_per ? per_trig : dma_trig) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk); iv = 1;
    while (!(use_per ? per_trig : dma_trig) && iv < 3000) begin
      if (use_per ? dma_trig : per_trig) other++;
      @(negedge clk); iv++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int iv, oth;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(AC, d); check("R1 ctrl", d, 32'h0);
    rd(AM, d); check("R1 cmp", d, 32'h00FF_FFFF);
    rd(AS, d); check("R1 stat", d, 32'h0);
    rd(AN, d); check("R1 cnt", d, 32'h0);
    check("R1 outs", {27'b0, irq, wake, dma_trig, per_trig, cfg_err}, 32'h0);

    // R8 enable pipeline and pause/resume, continuous mode
    c_mode = 2'b11; c_run = 1; put_ctrl();
    rd(AC, d); check("R8 active not yet", {31'b0, d[15]}, 32'h0);
    repeat (2) @(negedge clk);
    rd(AC, d); check("R8 active set", {31'b0, d[15]}, 32'h1);
    tick_n(6);
    c_run = 0; put_ctrl();
    repeat (3) @(negedge clk);
    tick_n(4);
    rd(AN, d); check("R8 paused hold", d, 32'd6);
    c_run = 1; put_ctrl();
    repeat (3) @(negedge clk);
    tick_n(3);
    rd(AN, d); check("R8 resume", d, 32'd9);

    // R9 count write clears, busy visible
    wr(AN, 32'h0);
    rd(AN, d); check("R9 busy", {31'b0, d[31]}, 32'h1);
    rd(AN, d); check("R9 cleared", d, 32'h0);

    // R12 debug halt
    dbg_halt = 1'b1;
    tick_n(5);
    rd(AN, d); check("R12 held", d, 32'h0);
    c_dbg = 1; put_ctrl();
    tick_n(5);
    rd(AN, d); check("R12 ignored", d, 32'd5);
    dbg_halt = 1'b0; c_dbg = 0; put_ctrl();

    // R10 prescale change clears; R2 division
    put_ctrl();
    rd(AN, d); check("R10 same psc", d, 32'd5);
    c_psc = 8'd3; put_ctrl();
    rd(AN, d); check("R10 new psc", d, 32'h0);
    tick_n(8);
    rd(AN, d); check("R2 div by 4", d, 32'd2);
    c_psc = 8'd0; put_ctrl();

    // R6 continuous: compare write keeps count
    tick_n(10);
    wr(AM, 32'd3);
    rd(AN, d); check("R6 cont keep", d, 32'd10);
    rd(AS, d); check("R6 no flag", d, 32'h0);

    // R7 periodic with select
    c_mode = 2'b01; c_ps = 1; put_ctrl();
    wr(AN, 32'h0); @(negedge clk);
    wr(AM, 32'd100);
    tick_n(10);
    wr(AM, 32'd20);
    rd(AN, d); check("R7 greater keeps", d, 32'd10);
    rd(AS, d); check("R7 greater no flag", d, 32'h0);
    wr(AM, 32'd10);
    rd(AS, d); check("R7 equal flag", d, 32'h1);
    rd(AN, d); check("R7 equal restart", d, 32'h0);
    wr(AS, 32'h1);
    wr(AM, 32'd100);
    tick_n(10);
    wr(AM, 32'd5);
    rd(AN, d); check("R7 less reset", d, 32'h0);
    rd(AS, d); check("R7 less no flag", d, 32'h0);

    // R6 periodic without select restarts
    c_ps = 0; put_ctrl();
    wr(AM, 32'd100);
    tick_n(10);
    wr(AM, 32'd50);
    rd(AN, d); check("R6 periodic restart", d, 32'h0);

    // R3 R13 periodic interval table with DMA trigger
    wr(AT, 32'h1);
    for (int i = 0; i < NV; i++) begin
      c_psc = 8'(VEC[i][0]); c_run = 0; put_ctrl();
      wr(AM, 32'(VEC[i][1]));
      tick_div = VEC[i][2]; tick_auto = 1'b1;
      c_run = 1; put_ctrl();
      measure(1'b0, iv, oth);
      tick_auto = 1'b0;
      check("R3 R13 periodic interval", 32'(iv),
            32'((VEC[i][0] + 1) * VEC[i][1] * VEC[i][2]));
      check("R13 no per pulse", 32'(oth), 32'h0);
    end
    c_run = 0; c_psc = 0; put_ctrl();
    wr(AS, 32'h1);

    // R13 peripheral trigger only
    wr(AT, 32'h2);
    wr(AM, 32'd4);
    tick_div = 1; tick_auto = 1'b1;
    c_run = 1; put_ctrl();
    measure(1'b1, iv, oth);
    tick_auto = 1'b0;
    check("R13 per interval", 32'(iv), 32'd4);
    check("R13 dma silent", 32'(oth), 32'h0);
    c_run = 0; put_ctrl();
    wr(AT, 32'h0);
    wr(AS, 32'h1);

    // R4 one-shot
    c_mode = 2'b00; put_ctrl();
    wr(AM, 32'd5);
    c_run = 1; put_ctrl();
    repeat (3) @(negedge clk);
    tick_n(5);
    c_run = 0;
    rd(AS, d); check("R4 R5 flag set", d, 32'h1);
    rd(AC, d); check("R4 run and active clear", {30'b0, d[15], d[10]}, 32'h0);
    tick_n(3);
    rd(AN, d); check("R4 stopped", d, 32'h0);

    // R5 write zero ignored; R11 irq and wake
    wr(AS, 32'h0);
    rd(AS, d); check("R5 zero write", d, 32'h1);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    c_ie = 1; put_ctrl();
    @(negedge clk);
    check("R11 irq on", {31'b0, irq}, 32'h1);
    c_we = 1; put_ctrl();
    @(negedge clk);
    check("R11 wake set", {31'b0, wake}, 32'h1);
    c_we = 0; put_ctrl();
    wr(AS, 32'h2);
    rd(AS, d); check("R11 wake cleared", d, 32'h1);
    wr(AS, 32'h1);
    rd(AS, d); check("R5 flag cleared", d, 32'h0);
    check("R11 irq off", {31'b0, irq}, 32'h0);
    c_ie = 0; put_ctrl();

    // R4 mode 10 acts as one-shot
    c_mode = 2'b10; put_ctrl();
    wr(AM, 32'd4);
    c_run = 1; put_ctrl();
    repeat (3) @(negedge clk);
    tick_n(4);
    c_run = 0;
    rd(AC, d); check("R4 mode10 run clear", {31'b0, d[10]}, 32'h0);
    rd(AS, d); check("R4 mode10 flag", d, 32'h1);

    // R14 illegal compare values
    wr(AM, 32'd1); @(negedge clk);
    check("R14 cmp1", {31'b0, cfg_err}, 32'h1);
    wr(AM, 32'd0); @(negedge clk);
    check("R14 cmp0", {31'b0, cfg_err}, 32'h1);
    wr(AM, 32'd2); @(negedge clk);
    check("R14 cmp2", {31'b0, cfg_err}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule